// File: doc/BRIEF.md
# Transmit Prefill Admission Controller

This block sits between a host controller's schedule walker and the transmit latency FIFO. When the walker offers a transmit packet (OUT or SETUP) in host mode, the block decides whether the packet may start filling the FIFO. It compares a time budget with the time left before the current frame or microframe ends. The budget is the fetch-time estimate plus the packet's overhead and payload times. Once it admits a fill, the block keeps watching the remaining time. If too little is left for the packet to reach the wire before the boundary, it aborts the fill. It then asks for the partly fetched data to be flushed, so that periodic traffic after the next start-of-frame has room. Each abort is counted in a saturating health counter. An abort is not an error: the scheduler simply offers the packet again later.

All time operands and the remaining-time input share one unit (bit times) and one width. The remaining-time input is a down-counter that reloads at each start-of-frame. Packet descriptors arrive over a valid/ready handshake. A descriptor transfers on a cycle where both `pkt_valid` and `pkt_ready` are high. The block holds `pkt_ready` low for the whole life of an accepted packet. The upstream side must keep its descriptor stable while `pkt_valid` is high and `pkt_ready` is low. Completion (`pkt_sent`), flush acknowledge and counter clear are plain control pins.

Top module: `prefill_admit_ctrl`

## Requirements
- R1: `pkt_ready` is high exactly when the controller is idle. A descriptor is taken on a cycle with `pkt_valid` and `pkt_ready` both high, and its kind, mode and time operands are captured on that edge.
- R2: For an admissible packet, the controller evaluates the budget in the cycle after the handshake. `prefill_start` pulses for one cycle when `remaining` >= fetch + overhead + payload. The sum is formed at full precision, with no wrap.
- R3: If the budget does not fit, `prefill_start` stays low. The check repeats every cycle, and the pulse comes in the first cycle where `remaining` reaches the budget (for example after a start-of-frame reload).
- R4: During the fill, `backoff` pulses for one cycle in any cycle where `remaining` < overhead + payload. This holds even if `fill_done` is high in the same cycle. A value exactly equal to overhead + payload does not back off.
- R5: From the cycle after a `backoff` pulse, `flush_req` stays high until a cycle with `flush_ack` high. `pkt_ready` is high in the following cycle.
- R6: When `fill_done` is high during the fill and no back-off occurs, `send_ready` is high from the next cycle until a cycle with `pkt_sent` high. `pkt_ready` is high in the following cycle.
- R7: The health counter (`health_count`, 8 bits) adds one on each `backoff` pulse and saturates at 255. A `health_clear` pulse zeroes it on the next edge. If a clear and a back-off fall on the same cycle, the clear wins.
- R8: A packet with kind IN (2) or reserved (3), or any packet taken with `host_mode` low, bypasses the check. `send_ready` is high from the cycle after the handshake, and neither `prefill_start` nor `backoff` pulses for it. Kinds OUT (0) and SETUP (1) are checked.
- R9: After reset, `pkt_ready` is 1, `prefill_start`, `backoff`, `flush_req` and `send_ready` are 0, and `health_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Descriptor valid |
| pkt_ready | output | 1 | Descriptor ready (controller idle) |
| pkt_kind | input | 2 | 0 OUT, 1 SETUP, 2 IN, 3 reserved |
| host_mode | input | 1 | Controller is operating as host |
| payload_time | input | 16 | Time to send the data payload |
| overhead_time | input | 16 | Standard packet overhead time |
| fetch_time | input | 16 | Estimated time to fill the FIFO to its level |
| remaining | input | 16 | Time left in the current frame or microframe |
| fill_done | input | 1 | FIFO reached its fill level |
| pkt_sent | input | 1 | Packet has gone onto the bus |
| flush_ack | input | 1 | Partial packet has been discarded |
| health_clear | input | 1 | Synchronous clear of the health counter |
| prefill_start | output | 1 | One-cycle pulse: begin filling the FIFO |
| backoff | output | 1 | One-cycle pulse: fill aborted |
| flush_req | output | 1 | Request to discard the partial packet |
| send_ready | output | 1 | Packet may go onto the bus |
| health_count | output | 8 | Saturating back-off count |

## Verification
The bound checker checks on every cycle that each start pulse had the budget available and that each back-off saw a remaining time below the flight time. It also checks that the flush request and the send-ready level hold until acknowledged, that at most one of the start, back-off and send-ready outputs is active at a time, and that the counter steps or saturates correctly. Other behaviours are only visible through the bench's scenarios. These are the deferral and later admission after a reload, the exact-equality boundaries, the bypass of IN and device-mode packets, back-off winning over a simultaneous fill-done, clear winning over a simultaneous back-off, and saturation after a long run of aborts.

// File: rtl/prefill_pkg.sv
package prefill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CHECK   = 3'd1,
    ST_FILL    = 3'd2,
    ST_READY   = 3'd3,
    ST_BACKOFF = 3'd4
  } adm_state_e;

  typedef enum logic [1:0] {
    KIND_OUT   = 2'd0,
    KIND_SETUP = 2'd1,
    KIND_IN    = 2'd2,
    KIND_RSVD  = 2'd3
  } pkt_kind_e;

  // True when the admission check applies to this packet.
  function automatic logic needs_check(input logic [1:0] kind, input logic host);
    return host && ((kind == KIND_OUT) || (kind == KIND_SETUP));
  endfunction
endpackage

// File: rtl/prefill_budget.sv
module prefill_budget #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] payload_t,
  input  logic [TIME_W-1:0] overhead_t,
  input  logic [TIME_W-1:0] fetch_t,
  input  logic [TIME_W-1:0] remaining,
  output logic [TIME_W:0]   flight_t,
  output logic [TIME_W+1:0] total_t,
  output logic              fits,
  output logic              too_short
);
  localparam int FW = TIME_W + 1;
  localparam int TW = TIME_W + 2;

  logic [FW-1:0] rem_f;
  logic [TW-1:0] rem_t;

  always_comb begin
    flight_t  = {1'b0, overhead_t} + {1'b0, payload_t};
    total_t   = {1'b0, flight_t} + {2'b00, fetch_t};
    rem_f     = {1'b0, remaining};
    rem_t     = {2'b00, remaining};
    fits      = (rem_t >= total_t);
    too_short = (rem_f < flight_t);
  end
endmodule

// File: rtl/prefill_health.sv
module prefill_health #(
  parameter int HC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            bump,
  output logic [HC_W-1:0] count
);
  localparam logic [HC_W-1:0] CMAX = {HC_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clear)
      count <= '0;
    else if (bump && (count != CMAX))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/prefill_fsm.sv
module prefill_fsm
  import prefill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       applies_now,
  input  logic       fits,
  input  logic       too_short,
  input  logic       fill_done,
  input  logic       pkt_sent,
  input  logic       flush_ack,
  output adm_state_e state,
  output logic       idle,
  output logic       start_pulse,
  output logic       backoff_pulse,
  output logic       flush_req,
  output logic       send_ready
);
  adm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (take) nxt = applies_now ? ST_CHECK : ST_READY;
      ST_CHECK:   if (fits) nxt = ST_FILL;
      ST_FILL: begin
        if (too_short)      nxt = ST_BACKOFF;
        else if (fill_done) nxt = ST_READY;
      end
      ST_READY:   if (pkt_sent)  nxt = ST_IDLE;
      ST_BACKOFF: if (flush_ack) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    idle          = (state == ST_IDLE);
    start_pulse   = (state == ST_CHECK) && fits;
    backoff_pulse = (state == ST_FILL) && too_short;
    flush_req     = (state == ST_BACKOFF);
    send_ready    = (state == ST_READY);
  end
endmodule

// File: rtl/prefill_admit_ctrl.sv
module prefill_admit_ctrl
  import prefill_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int HC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [1:0]        pkt_kind,
  input  logic              host_mode,
  input  logic [TIME_W-1:0] payload_time,
  input  logic [TIME_W-1:0] overhead_time,
  input  logic [TIME_W-1:0] fetch_time,
  input  logic [TIME_W-1:0] remaining,
  input  logic              fill_done,
  input  logic              pkt_sent,
  input  logic              flush_ack,
  input  logic              health_clear,
  output logic              prefill_start,
  output logic              backoff,
  output logic              flush_req,
  output logic              send_ready,
  output logic [HC_W-1:0]   health_count
);
  logic              take;
  logic              applies_now;
  logic [TIME_W-1:0] pay_q, ovh_q, fet_q;
  logic [TIME_W:0]   flight_t;
  logic [TIME_W+1:0] total_t;
  logic              fits, too_short, idle;
  adm_state_e        state;

  assign take        = pkt_valid && idle;
  assign applies_now = needs_check(pkt_kind, host_mode);
  assign pkt_ready   = idle;

  // Operand capture on the handshake edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
      ovh_q <= '0;
      fet_q <= '0;
    end else if (take) begin
      pay_q <= payload_time;
      ovh_q <= overhead_time;
      fet_q <= fetch_time;
    end
  end

  prefill_budget #(.TIME_W(TIME_W)) u_budget (
    .payload_t (pay_q),
    .overhead_t(ovh_q),
    .fetch_t   (fet_q),
    .remaining (remaining),
    .flight_t  (flight_t),
    .total_t   (total_t),
    .fits      (fits),
    .too_short (too_short)
  );

  prefill_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .applies_now  (applies_now),
    .fits         (fits),
    .too_short    (too_short),
    .fill_done    (fill_done),
    .pkt_sent     (pkt_sent),
    .flush_ack    (flush_ack),
    .state        (state),
    .idle         (idle),
    .start_pulse  (prefill_start),
    .backoff_pulse(backoff),
    .flush_req    (flush_req),
    .send_ready   (send_ready)
  );

  prefill_health #(.HC_W(HC_W)) u_health (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(health_clear),
    .bump (backoff),
    .count(health_count)
  );
endmodule

// File: rtl/prefill_admit_chk.sv
module prefill_admit_chk #(
  parameter int TIME_W = 16,
  parameter int HC_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [TIME_W-1:0] payload_time,
  input logic [TIME_W-1:0] overhead_time,
  input logic [TIME_W-1:0] fetch_time,
  input logic [TIME_W-1:0] remaining,
  input logic              pkt_sent,
  input logic              flush_ack,
  input logic              health_clear,
  input logic              prefill_start,
  input logic              backoff,
  input logic              flush_req,
  input logic              send_ready,
  input logic [HC_W-1:0]   health_count
);
  localparam logic [HC_W-1:0] CMAX = {HC_W{1'b1}};
  logic [TIME_W+1:0] c_total;
  logic [TIME_W+1:0] c_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_total  <= '0;
      c_flight <= '0;
    end else if (pkt_valid && pkt_ready) begin
      c_flight <= {2'b00, overhead_time} + {2'b00, payload_time};
      c_total  <= {2'b00, overhead_time} + {2'b00, payload_time} + {2'b00, fetch_time};
    end
  end

  p_start_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prefill_start |-> ({2'b00, remaining} >= c_total));
  p_backoff_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |-> ({2'b00, remaining} < c_flight));
  p_flush_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |=> flush_req);
  p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (send_ready && !pkt_sent) |=> send_ready);
  p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> !(send_ready || flush_req || prefill_start || backoff));
  p_outputs_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prefill_start, backoff, send_ready, flush_req}));
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff && !health_clear && health_count != CMAX) |=> health_count == $past(health_count) + 1'b1);
  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (health_count == CMAX && !health_clear) |=> health_count == CMAX);
  p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    health_clear |=> health_count == '0);
  p_count_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!backoff && !health_clear) |=> $stable(health_count));
endmodule

bind prefill_admit_ctrl prefill_admit_chk #(.TIME_W(TIME_W), .HC_W(HC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .payload_time(payload_time), .overhead_time(overhead_time), .fetch_time(fetch_time),
  .remaining(remaining), .pkt_sent(pkt_sent), .flush_ack(flush_ack),
  .health_clear(health_clear), .prefill_start(prefill_start), .backoff(backoff),
  .flush_req(flush_req), .send_ready(send_ready), .health_count(health_count)
);

// File: tb/sim_prefill_admit_ctrl.sv
`timescale 1ns/1ps
module sim_prefill_admit_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pkt_valid = 0, host_mode = 1;
  logic [1:0]  pkt_kind = 0;
  logic [15:0] payload_time = 0, overhead_time = 0, fetch_time = 0, remaining = 0;
  logic        fill_done = 0, pkt_sent = 0, flush_ack = 0, health_clear = 0;
  logic        pkt_ready, prefill_start, backoff, flush_req, send_ready;
  logic [7:0]  health_count;

  int checks = 0, errors = 0;
  int exp_hc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prefill_admit_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_kind(pkt_kind), .host_mode(host_mode), .payload_time(payload_time),
    .overhead_time(overhead_time), .fetch_time(fetch_time), .remaining(remaining),
    .fill_done(fill_done), .pkt_sent(pkt_sent), .flush_ack(flush_ack),
    .health_clear(health_clear), .prefill_start(prefill_start), .backoff(backoff),
    .flush_req(flush_req), .send_ready(send_ready), .health_count(health_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fits_f(int pay, int ov, int fet, int rem);
    return rem >= pay + ov + fet;
  endfunction

  function automatic bit short_f(int pay, int ov, int rem);
    return rem < pay + ov;
  endfunction

  function automatic int hc_next(int hc, bit bo, bit clr);
    if (clr) return 0;
    if (bo && hc < 255) return hc + 1;
    return hc;
  endfunction

  // Present a descriptor; returns at the negedge after the handshake edge.
  task automatic offer(input int kind, input bit host, input int pay, input int ov,
                       input int fet, input int rem);
    @(negedge clk);
    pkt_kind = kind[1:0]; host_mode = host;
    payload_time = pay[15:0]; overhead_time = ov[15:0]; fetch_time = fet[15:0];
    remaining = rem[15:0]; pkt_valid = 1;
    #0.5 check("R1 pkt_ready while idle", pkt_ready, 1);
    @(negedge clk);
    pkt_valid = 0;
    check("R1 pkt_ready low after take", pkt_ready, 0);
  endtask

  // Called in FILL state at a negedge. Applies the final fill cycle.
  task automatic finish_fill(input int pay, input int ov, input int rem_fill,
                             input bit clr);
    bit exp_bo;
    exp_bo = short_f(pay, ov, rem_fill);
    remaining = rem_fill[15:0]; fill_done = 1; health_clear = clr;
    #0.5 check("R4 backoff pulse on final fill cycle", backoff, exp_bo);
    exp_hc = hc_next(exp_hc, exp_bo, clr);
    @(negedge clk);
    fill_done = 0; health_clear = 0;
    check("R7 health count", health_count, exp_hc);
    check("R4 backoff is one cycle", backoff, 0);
    if (exp_bo) begin
      check("R5 flush_req after backoff", flush_req, 1);
      check("R6 no send_ready on backoff", send_ready, 0);
      @(negedge clk);
      check("R5 flush_req held", flush_req, 1);
      flush_ack = 1;
      @(negedge clk);
      flush_ack = 0;
      check("R5 idle after flush_ack", pkt_ready, 1);
      check("R5 flush_req drops", flush_req, 0);
    end else begin
      check("R6 send_ready after fill_done", send_ready, 1);
      @(negedge clk);
      check("R6 send_ready held", send_ready, 1);
      pkt_sent = 1;
      @(negedge clk);
      pkt_sent = 0;
      check("R6 idle after pkt_sent", pkt_ready, 1);
      check("R6 send_ready drops", send_ready, 0);
    end
  endtask

  // Full checked packet: admission (with deferral), waits, then final fill cycle.
  task automatic run_pkt(input int pay, input int ov, input int fet, input int rem,
                         input int waits, input int rem_fill, input bit clr);
    offer(0, 1, pay, ov, fet, rem);
    check("R2 prefill_start on budget", prefill_start, fits_f(pay, ov, fet, rem));
    if (!fits_f(pay, ov, fet, rem)) begin
      @(negedge clk);
      check("R3 deferred, no start", prefill_start, 0);
      remaining = 16'hFFFF;
      #0.5 check("R3 start after reload", prefill_start, 1);
    end
    remaining = 16'hFFFF; fill_done = 0;
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      check("R2 start is one cycle", prefill_start, 0);
      check("R4 no backoff with time left", backoff, 0);
    end
    finish_fill(pay, ov, rem_fill, clr);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R9 reset pkt_ready", pkt_ready, 1);
    check("R9 reset outputs", {prefill_start, backoff, flush_req, send_ready}, 0);
    check("R9 reset health", health_count, 0);
    rst_n = 1;
    @(negedge clk);

    // Exact budget admits; exact flight does not back off.
    run_pkt(30, 20, 10, 60, 1, 50, 0);
    // One short of budget defers; one short of flight backs off.
    run_pkt(30, 20, 10, 59, 2, 49, 0);
    // SETUP kind checked as well.
    offer(1, 1, 5, 5, 5, 14);
    check("R2 SETUP checked, no start", prefill_start, 0);
    remaining = 15;
    #0.5 check("R3 SETUP start when budget met", prefill_start, 1);
    @(negedge clk);
    finish_fill(5, 5, 100, 0);
    // Back-off wins over simultaneous fill_done (finish_fill drives both).
    run_pkt(100, 100, 0, 500, 3, 199, 0);

    // Bypass: IN kind, reserved kind, device mode.
    offer(2, 1, 1000, 1000, 1000, 0);
    check("R8 IN no prefill_start", prefill_start, 0);
    check("R8 IN send_ready", send_ready, 1);
    pkt_sent = 1; @(negedge clk); pkt_sent = 0;
    check("R8 idle after IN", pkt_ready, 1);
    offer(3, 1, 1000, 1000, 1000, 0);
    check("R8 reserved kind send_ready", send_ready, 1);
    pkt_sent = 1; @(negedge clk); pkt_sent = 0;
    offer(0, 0, 1000, 1000, 1000, 0);
    check("R8 device mode no start", prefill_start, 0);
    check("R8 device mode send_ready", send_ready, 1);
    remaining = 0;
    @(negedge clk);
    check("R8 device mode no backoff", backoff, 0);
    pkt_sent = 1; @(negedge clk); pkt_sent = 0;
    check("R8 health unchanged", health_count, exp_hc);

    // Clear wins over simultaneous back-off.
    run_pkt(10, 10, 10, 100, 1, 0, 1);
    check("R7 clear beats backoff", health_count, 0);

    // Saturation.
    for (int i = 0; i < 260; i++) run_pkt(10, 10, 10, 100, 1, 5, 0);
    check("R7 saturated at 255", health_count, 255);
    @(negedge clk); health_clear = 1;
    @(negedge clk); health_clear = 0; exp_hc = 0;
    check("R7 clear pulse", health_count, 0);

    // Random packets.
    for (int i = 0; i < 300; i++) begin
      int pay, ov, fet, rem, rf, w;
      pay = $urandom_range(0, 1500);
      ov  = $urandom_range(0, 200);
      fet = $urandom_range(0, 800);
      rem = $urandom_range(0, 4000);
      rf  = $urandom_range(0, 2500);
      w   = $urandom_range(1, 4);
      run_pkt(pay, ov, fet, rem, w, rf, ($urandom_range(0, 15) == 0));
    end

    // Full-precision sum: budget of 65536 never fits a 16-bit remaining.
    offer(0, 1, 16'hFFF0, 16'h0010, 0, 16'hFFFF);
    check("R2 no wrap in budget sum", prefill_start, 0);
    @(negedge clk);
    check("R3 still deferred", prefill_start, 0);
    rst_n = 0;
    @(negedge clk);
    check("R9 reset returns to idle", pkt_ready, 1);
    check("R9 reset clears health", health_count, 0);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule